// File: doc/BRIEF.md
# Diagonal Propagation Matrix Arbiter

This block is the scheduler of an N×N crossbar (N = 4 by default). On every clock it takes a request matrix, in which bit `i*N + j` set means input `i` wants output `j`. From that matrix it forms a grant matrix with no conflicts: each input gets at most one output, and each output is given to at most one input. Data switching is left to the fabric that consumes the grants.

**Diagonals and rounds.** Cells whose row and column indices add up to the same value modulo N form one wrapped diagonal. No two cells on a diagonal share a row or a column, so every requesting cell on a diagonal can be granted at once. The cell array holds 2N-1 diagonal rounds, because the first N-1 diagonals appear a second time after the last one. A window-select vector with N set bits chooses N consecutive rounds as active.

**Ordering and rotation.** Within the window, rounds are taken from first to last. A cell in a later round is granted only if nothing earlier in the window has claimed its row or its column. Each pulse of the time-slot enable moves the window down by one round. After the last position the window returns to the first. As a result every diagonal becomes the highest-priority one once in every N slots. The grant matrix is registered.

Top module: `dpa_arbiter`

## Requirements
- R1: While reset is high, the grant matrix becomes all zero on the next clock. Reset also returns the window to start position 0, so that diagonal 0 has the highest priority.
- R2: No row and no column of the grant matrix ever holds more than one set bit.
- R3: A grant bit is set only if the same bit of the request matrix was set at the preceding clock edge.
- R4: Every requesting cell on the highest-priority diagonal is granted. This holds even when the requests on that diagonal fill all N rows.
- R5: A requesting cell that is not granted always finds another grant in its row or in its column.
- R6: Bit `i*N + j` of `req` and of `gnt` stands for input `i` and output `j`. The cell lies on diagonal `(i + j) mod N`. With window start `s`, diagonals are served in the order s, s+1, … (mod N).
- R7: A clock edge with `slot_en` high advances the window start from s to (s + 1) mod N. Position N-1 therefore wraps back to 0. Exactly N rounds are active at all times.
- R8: While `slot_en` is low, the window start does not change.
- R9: The grant matrix on the outputs is computed from the request matrix and the window position present at the previous rising edge of `clk`. It is therefore one cycle late.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_en | input | 1 | Time-slot pulse that moves the priority window one round |
| req | input | N*N | Request matrix, bit i*N+j = input i asks for output j |
| gnt | output | N*N | Registered grant matrix, same bit layout as `req` |

## Verification
A set of fixed patterns separates the two kinds of contention:
- Patterns that load one column or one row show whether contention is settled by diagonal order.
- A full diagonal and a full matrix show that independent cells are granted together.
- A three-cell overlap shows that a cell blocked in its row, or blocked in its column, loses correctly.

A column-0 pattern under repeated slot pulses shows the winner moving row by row and wrapping back. The same pattern without pulses shows that the window holds. Random matrices under a changing window are compared against a sequential model of the diagonal order, and the bench also checks them for row and column conflicts.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

    // Inputs seen by one arbitration cell.
    typedef struct packed {
        logic req;       // request for this input/output pair
        logic act;       // the round holding this cell lies inside the window
        logic row_free;  // no earlier round granted this input
        logic col_free;  // no earlier round granted this output
    } cell_in_t;

    // Outputs passed on by one arbitration cell.
    typedef struct packed {
        logic gnt;
        logic row_free;
        logic col_free;
    } cell_out_t;

    // Column served by row i in round q: the cell with (i + col) mod n == q mod n.
    function automatic int col_of(input int q, input int i, input int n);
        return (((q - i) % n) + n) % n;
    endfunction

    // Starting window: the lowest n rounds are active.
    function automatic logic [63:0] win_init(input int n);
        logic [63:0] v;
        v = '0;
        for (int k = 0; k < n; k++) v[k] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/dpa_cell.sv
module dpa_cell
    import dpa_pkg::*;
(
    input  cell_in_t  cin,
    output cell_out_t cout
);
    logic take;

    always_comb begin
        take          = cin.act & cin.req & cin.row_free & cin.col_free;
        cout.gnt      = take;
        cout.row_free = cin.row_free & ~take;
        cout.col_free = cin.col_free & ~take;
    end
endmodule

// File: rtl/dpa_window_ctl.sv
module dpa_window_ctl #(
    parameter int N = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_en,
    output logic [2*N-2:0]    win_q
);
    localparam int ROWS = 2 * N - 1;
    localparam logic [ROWS-1:0] WIN_FIRST = ROWS'(dpa_pkg::win_init(N));
    localparam logic [ROWS-1:0] WIN_LAST  = WIN_FIRST << (N - 1);

    always_ff @(posedge clk) begin
        if (rst)
            win_q <= WIN_FIRST;
        else if (slot_en)
            win_q <= (win_q == WIN_LAST) ? WIN_FIRST : (win_q << 1);
    end

    AST_WIN_POP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($countones(win_q) == N)); // R7

    AST_WIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(slot_en)) |-> (win_q == $past(win_q))); // R8

    AST_WIN_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(slot_en)) |-> (win_q != $past(win_q))); // R7
endmodule

// File: rtl/dpa_cell_array.sv
module dpa_cell_array
    import dpa_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N*N-1:0]  req,
    input  logic [2*N-2:0]  win,
    output logic [N*N-1:0]  gnt
);
    localparam int ROWS = 2 * N - 1;

    logic [N-1:0] row_free [ROWS+1];
    logic [N-1:0] col_free [ROWS+1];
    logic [N-1:0] hit      [ROWS];

    assign row_free[0] = '1;
    assign col_free[0] = '1;

    for (genvar q = 0; q < ROWS; q++) begin : g_round
        for (genvar i = 0; i < N; i++) begin : g_row
            localparam int J = col_of(q, i, N);
            cell_in_t  ci;
            cell_out_t co;

            assign ci.req      = req[i*N + J];
            assign ci.act      = win[q];
            assign ci.row_free = row_free[q][i];
            assign ci.col_free = col_free[q][J];

            dpa_cell u_cell (.cin(ci), .cout(co));

            assign hit[q][i]          = co.gnt;
            assign row_free[q+1][i]   = co.row_free;
            assign col_free[q+1][J]   = co.col_free;
        end
    end

    always_comb begin
        gnt = '0;
        for (int q = 0; q < ROWS; q++)
            for (int i = 0; i < N; i++)
                gnt[i*N + col_of(q, i, N)] = gnt[i*N + col_of(q, i, N)] | hit[q][i];
    end
endmodule

// File: rtl/dpa_arbiter.sv
module dpa_arbiter #(
    parameter int N = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slot_en,
    input  logic [N*N-1:0]   req,
    output logic [N*N-1:0]   gnt
);
    localparam int ROWS  = 2 * N - 1;
    localparam int CELLS = N * N;

    logic [ROWS-1:0]  win;
    logic [CELLS-1:0] gnt_next;
    logic [CELLS-1:0] gnt_q;

    dpa_window_ctl #(.N(N)) u_win (
        .clk     (clk),
        .rst     (rst),
        .slot_en (slot_en),
        .win_q   (win)
    );

    dpa_cell_array #(.N(N)) u_array (
        .req (req),
        .win (win),
        .gnt (gnt_next)
    );

    always_ff @(posedge clk) begin
        if (rst) gnt_q <= '0;
        else     gnt_q <= gnt_next;
    end

    assign gnt = gnt_q;

    // Row and column views of the registered grant matrix.
    logic [N-1:0] row_vec [N];
    logic [N-1:0] col_vec [N];
    always_comb begin
        for (int a = 0; a < N; a++)
            for (int b = 0; b < N; b++) begin
                row_vec[a][b] = gnt_q[a*N + b];
                col_vec[a][b] = gnt_q[b*N + a];
            end
    end

    AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> (gnt_q == '0)); // R1

    AST_GNT_SUBSET: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((gnt_q & ~$past(req)) == '0)); // R3

    for (genvar a = 0; a < N; a++) begin : g_line
        AST_ROW_SINGLE: assert property (@(posedge clk) disable iff (rst)
            $onehot0(row_vec[a])); // R2
        AST_COL_SINGLE: assert property (@(posedge clk) disable iff (rst)
            $onehot0(col_vec[a])); // R2
        for (genvar b = 0; b < N; b++) begin : g_cell
            AST_LOSER_BLOCKED: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(req[a*N + b]) && !gnt_q[a*N + b])
                |-> ((|row_vec[a]) || (|col_vec[b]))); // R5
        end
    end
endmodule

// File: tb/sim_dpa_arbiter.sv
`timescale 1ns/1ps
module sim_dpa_arbiter;
    localparam int N = 4;
    localparam int C = N * N;
    localparam int NV = 8;

    // Fixed vectors, all evaluated with window start 0.
    localparam logic [C-1:0] TBL_REQ [NV] = '{
        16'hFFFF, 16'h1111, 16'h8888, 16'h0F00,
        16'h0000, 16'h0012, 16'h0026, 16'h4812 };
    localparam logic [C-1:0] TBL_EXP [NV] = '{
        16'h2481, 16'h0001, 16'h0080, 16'h0400,
        16'h0000, 16'h0012, 16'h0002, 16'h4812 };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic slot_en = 1'b0;
    logic [C-1:0] req = '0;
    logic [C-1:0] gnt;

    int n_run = 0;
    int n_fail = 0;
    int s_m = 0;

    always #2.5 clk = ~clk;

    dpa_arbiter #(.N(N)) u0 (
        .clk(clk), .rst(rst), .slot_en(slot_en), .req(req), .gnt(gnt));

    task automatic check(input string tag, input logic [C-1:0] act, input logic [C-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference: serve diagonals in window order, claiming rows and columns.
    function automatic logic [C-1:0] model(input logic [C-1:0] r, input int s);
        logic [N-1:0] rf, cf;
        logic [C-1:0] g;
        rf = '1; cf = '1; g = '0;
        for (int t = 0; t < N; t++) begin
            for (int i = 0; i < N; i++) begin
                int k, j;
                k = (s + t) % N;
                j = (k - i + N) % N;
                if (r[i*N+j] && rf[i] && cf[j]) begin
                    g[i*N+j] = 1'b1; rf[i] = 1'b0; cf[j] = 1'b0;
                end
            end
        end
        return g;
    endfunction

    function automatic bit conflict_free(input logic [C-1:0] g);
        for (int a = 0; a < N; a++) begin
            int rc, cc;
            rc = 0; cc = 0;
            for (int b = 0; b < N; b++) begin
                rc += int'(g[a*N+b]);
                cc += int'(g[b*N+a]);
            end
            if (rc > 1 || cc > 1) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic drive(input logic [C-1:0] v);
        @(negedge clk); req = v;
        @(posedge clk); #1;
    endtask

    task automatic advance();
        @(negedge clk); slot_en = 1'b1;
        @(negedge clk); slot_en = 1'b0;
        s_m = (s_m + 1) % N;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        // R1: reset clears grants even with every request set
        req = '1;
        repeat (3) @(posedge clk);
        #1 check("R1 reset grant", gnt, '0);
        @(negedge clk); rst = 1'b0;

        // R4 R5 R6: table walk at window start 0
        for (int v = 0; v < NV; v++) begin
            drive(TBL_REQ[v]);
            check($sformatf("R4/R5/R6 table %0d", v), gnt, TBL_EXP[v]);
        end

        // R7: column-0 contention winner follows the window start, then wraps
        for (int k = 1; k <= N; k++) begin
            advance();
            drive(16'h1111);
            check($sformatf("R7 rotate step %0d", k), gnt, C'(1) << (N * (k % N)));
        end

        // R8: without slot pulses the winner stays
        for (int k = 0; k < 3; k++) begin
            drive(16'h1111);
            check("R8 hold window", gnt, 16'h0001);
        end

        // R6: full matrix at start 1 grants diagonal 1
        advance();
        drive(16'hFFFF);
        check("R6 full matrix start 1", gnt, 16'h4812);

        // R9: one cycle of latency
        drive(16'h1111);
        @(negedge clk); req = 16'h8888;
        #0.5 check("R9 before edge", gnt, 16'h0010);
        @(posedge clk); #1;
        check("R9 after edge", gnt, model(16'h8888, s_m));

        // R1: reset mid-run restores window start 0
        advance();
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check("R1 mid-run clear", gnt, '0);
        @(negedge clk); rst = 1'b0; s_m = 0;
        drive(16'h1111);
        check("R1 window reset", gnt, 16'h0001);

        // R2 R5: random matrices under a moving window
        for (int k = 0; k < 60; k++) begin
            logic [C-1:0] r;
            r = C'($urandom);
            if (k % 3 == 2) advance();
            drive(r);
            check($sformatf("R5 random %0d", k), gnt, model(r, s_m));
            check($sformatf("R2 random %0d", k), {15'd0, conflict_free(gnt)}, 16'h0001);
        end

        summary();
        $finish;
    end
endmodule